// File: doc/BRIEF.md
# Per-Area Byte-Order Swap Controller

This block sits in an external bus interface. By default it treats every address area as big-endian. A single control register can mark at most one area, numbered 1 to 5, for little-endian handling. For each access, the bus logic supplies an area index that has already been decoded, together with the access size. The block then returns the write and read data with their byte lanes rearranged for that area, and raises a flag whenever the little-endian path is in use.

The control register can be written once after each reset. Only the first write to its offset (0x7FE) after reset takes effect. Every later write is dropped until the next reset, so a fault in software cannot change the byte order of a live area. The swap decision and the lane rearrangement are pure logic, so they add no cycle to the data path.

Top module: `endian_swap_ctrl`

## Requirements
- R1: When `le_flag` is low, `wr_data_out` equals `wr_data_in` and `rd_data_out` equals `rd_data_in`.
- R2: A stored code of 1 to 5 selects the area with that same number. `le_flag` is high only while `acc_area` equals the stored code.
- R3: Area 0 is never handled as little-endian, whatever code is stored.
- R4: After a synchronous reset the stored code is 0, no area is little-endian, and the register accepts a write again.
- R5: Only the first write to offset 0x7FE after reset is stored. It takes the code from `cfg_wdata[2:0]`. Every later write is ignored until the next reset.
- R6: Stored codes 6 and 7 behave like code 0, so no area is little-endian.
- R7: A write to any offset other than 0x7FE changes nothing and does not use up the single allowed write.
- R8: Bits of `cfg_wdata` above bit 2 have no effect on the stored code.
- R9: For a word access (`acc_size`=10) in the little-endian area, the byte lanes are fully reversed. Bits [7:0] swap with [31:24], and bits [15:8] swap with [23:16]. This applies in both data directions.
- R10: For a halfword access (`acc_size`=01) in the little-endian area, the two bytes inside each 16-bit half are exchanged. Bits [31:24] swap with [23:16], and bits [15:8] swap with [7:0].
- R11: For a byte access (`acc_size`=00) in the little-endian area, the lane position is mirrored using the same mapping as R9.
- R12: Size code 11 passes the data through unchanged, even in the little-endian area. `le_flag` still follows R2.
- R13: `le_flag` and both data outputs follow `acc_area`, `acc_size` and the data inputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_addr | input | 12 | Control write offset |
| cfg_wdata | input | 8 | Control write data; code in bits [2:0] |
| acc_area | input | 3 | Decoded area index of the current access |
| acc_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| wr_data_in | input | 32 | Write data from the core |
| rd_data_in | input | 32 | Read data from the bus |
| wr_data_out | output | 32 | Lane-corrected write data to the bus |
| rd_data_out | output | 32 | Lane-corrected read data to the core |
| le_flag | output | 1 | Current access uses little-endian handling |

## Verification
The bench attacks the write-once register in several ways. It sends a write to a neighbouring offset, which a sloppy decoder would store or count as the one allowed write. It sends a second write after the first, which a design without the sticky gate would accept, moving the swapped area. It sends a write with high data bits set, which would corrupt the code if those bits reached the stored value. It loads codes 6 and 7, which an unguarded comparator could match against areas 6 and 7. It confirms that area 0 stays big-endian. It checks every access size against byte patterns that are all distinct, so a swap of the wrong pair of lanes or a wrong size decode shows up as a data mismatch. A final check changes the inputs between clock edges to catch an output register added by mistake.

// File: rtl/endian_swap_pkg.sv
package endian_swap_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    LANE_KEEP    = 2'b00,
    LANE_REVERSE = 2'b01,
    LANE_PAIR    = 2'b10
  } lane_map_e;

  // Choose the lane rearrangement for one access.
  function automatic lane_map_e lane_map_for(input logic le, input acc_size_e sz);
    lane_map_e m;
    m = LANE_KEEP;
    if (le) begin
      case (sz)
        SZ_WORD: m = LANE_REVERSE;
        SZ_BYTE: m = LANE_REVERSE;
        SZ_HALF: m = LANE_PAIR;
        default: m = LANE_KEEP;
      endcase
    end
    return m;
  endfunction

endpackage

// File: rtl/endian_cfg_reg.sv
module endian_cfg_reg #(
  parameter int ADDR_W = 12,
  parameter int REG_W  = 8,
  parameter int CODE_W = 3,
  parameter logic [ADDR_W-1:0] REG_OFS = 12'h7FE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [CODE_W-1:0] code,
  output logic              done
);

  logic hit;
  logic unused_hi;

  assign hit       = we && (addr == REG_OFS) && !done;
  assign unused_hi = ^wdata[REG_W-1:CODE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= '0;
      done <= 1'b0;
    end else if (hit) begin
      code <= wdata[CODE_W-1:0];
      done <= 1'b1;
    end
  end

endmodule

// File: rtl/endian_area_match.sv
module endian_area_match #(
  parameter int AREA_W   = 3,
  parameter int CODE_W   = 3,
  parameter int MAX_AREA = 5
) (
  input  logic [AREA_W-1:0] area,
  input  logic [CODE_W-1:0] code,
  output logic              le
);

  localparam int CMP_W = (AREA_W > CODE_W) ? AREA_W : CODE_W;

  logic [CMP_W-1:0] area_x;
  logic [CMP_W-1:0] code_x;
  logic             code_ok;

  assign area_x  = CMP_W'(area);
  assign code_x  = CMP_W'(code);
  assign code_ok = (code_x != '0) && (code_x <= CMP_W'(MAX_AREA));
  assign le      = code_ok && (area_x == code_x);

endmodule

// File: rtl/endian_lane_swap.sv
module endian_lane_swap
  import endian_swap_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  lane_map_e         map,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  localparam int LANES = DATA_W / 8;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int SRC_REV  = LANES - 1 - g;
    localparam int SRC_PAIR = g ^ 1;
    assign dout[g*8 +: 8] = (map == LANE_REVERSE) ? din[SRC_REV*8 +: 8]  :
                            (map == LANE_PAIR)    ? din[SRC_PAIR*8 +: 8] :
                                                    din[g*8 +: 8];
  end

endmodule

// File: rtl/endian_swap_ctrl.sv
module endian_swap_ctrl
  import endian_swap_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int AREA_W   = 3,
  parameter int CODE_W   = 3,
  parameter int ADDR_W   = 12,
  parameter int REG_W    = 8,
  parameter int MAX_AREA = 5,
  parameter logic [ADDR_W-1:0] REG_OFS = 12'h7FE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic [AREA_W-1:0] acc_area,
  input  logic [1:0]        acc_size,
  input  logic [DATA_W-1:0] wr_data_in,
  input  logic [DATA_W-1:0] rd_data_in,
  output logic [DATA_W-1:0] wr_data_out,
  output logic [DATA_W-1:0] rd_data_out,
  output logic              le_flag
);

  logic [CODE_W-1:0] cfg_code;
  logic              cfg_done;
  logic              area_le;
  lane_map_e         lane_map;

  endian_cfg_reg #(
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W),
    .CODE_W (CODE_W),
    .REG_OFS(REG_OFS)
  ) u_cfg (
    .clk  (clk),
    .rst  (rst),
    .we   (cfg_we),
    .addr (cfg_addr),
    .wdata(cfg_wdata),
    .code (cfg_code),
    .done (cfg_done)
  );

  endian_area_match #(
    .AREA_W  (AREA_W),
    .CODE_W  (CODE_W),
    .MAX_AREA(MAX_AREA)
  ) u_match (
    .area(acc_area),
    .code(cfg_code),
    .le  (area_le)
  );

  assign lane_map = lane_map_for(area_le, acc_size_e'(acc_size));
  assign le_flag  = area_le;

  endian_lane_swap #(.DATA_W(DATA_W)) u_wr_swap (
    .map (lane_map),
    .din (wr_data_in),
    .dout(wr_data_out)
  );

  endian_lane_swap #(.DATA_W(DATA_W)) u_rd_swap (
    .map (lane_map),
    .din (rd_data_in),
    .dout(rd_data_out)
  );

endmodule

// File: rtl/endian_swap_chk.sv
module endian_swap_chk #(
  parameter int DATA_W   = 32,
  parameter int AREA_W   = 3,
  parameter int CODE_W   = 3,
  parameter int ADDR_W   = 12,
  parameter int REG_W    = 8,
  parameter int MAX_AREA = 5,
  parameter logic [ADDR_W-1:0] REG_OFS = 12'h7FE
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [REG_W-1:0]  cfg_wdata,
  input logic [AREA_W-1:0] acc_area,
  input logic [1:0]        acc_size,
  input logic [DATA_W-1:0] wr_data_in,
  input logic [DATA_W-1:0] rd_data_in,
  input logic [DATA_W-1:0] wr_data_out,
  input logic [DATA_W-1:0] rd_data_out,
  input logic              le_flag,
  input logic [CODE_W-1:0] cfg_code,
  input logic              cfg_done
);

  AST_BIG_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    !le_flag |-> (wr_data_out == wr_data_in) && (rd_data_out == rd_data_in)); // R1

  AST_ONLY_CODED_AREA: assert property (@(posedge clk) disable iff (rst)
    le_flag |-> (CODE_W'(acc_area) == cfg_code)); // R2

  AST_AREA0_BIG: assert property (@(posedge clk) disable iff (rst)
    (acc_area == '0) |-> !le_flag); // R3

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_code == '0) && !cfg_done); // R4

  AST_FIRST_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!cfg_done && cfg_we && cfg_addr == REG_OFS) |=>
      cfg_done && (cfg_code == $past(cfg_wdata[CODE_W-1:0]))); // R5

  AST_LOCKED: assert property (@(posedge clk) disable iff (rst)
    cfg_done |=> $stable(cfg_code) && cfg_done); // R5

  AST_HIGH_CODE_NONE: assert property (@(posedge clk) disable iff (rst)
    (cfg_code > CODE_W'(MAX_AREA)) |-> !le_flag); // R6

  AST_WORD_REVERSE: assert property (@(posedge clk) disable iff (rst)
    (le_flag && acc_size == 2'b10) |->
      (rd_data_out == {<<8{rd_data_in}}) && (wr_data_out == {<<8{wr_data_in}})); // R9

endmodule

bind endian_swap_ctrl endian_swap_chk #(
  .DATA_W  (DATA_W),
  .AREA_W  (AREA_W),
  .CODE_W  (CODE_W),
  .ADDR_W  (ADDR_W),
  .REG_W   (REG_W),
  .MAX_AREA(MAX_AREA),
  .REG_OFS (REG_OFS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_we     (cfg_we),
  .cfg_addr   (cfg_addr),
  .cfg_wdata  (cfg_wdata),
  .acc_area   (acc_area),
  .acc_size   (acc_size),
  .wr_data_in (wr_data_in),
  .rd_data_in (rd_data_in),
  .wr_data_out(wr_data_out),
  .rd_data_out(rd_data_out),
  .le_flag    (le_flag),
  .cfg_code   (cfg_code),
  .cfg_done   (cfg_done)
);

// File: tb/sim_endian_swap_ctrl.sv
`timescale 1ns/1ps
module sim_endian_swap_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [2:0]  acc_area = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] wr_data_in = '0;
  logic [31:0] rd_data_in = '0;
  logic [31:0] wr_data_out;
  logic [31:0] rd_data_out;
  logic        le_flag;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  endian_swap_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .acc_area(acc_area), .acc_size(acc_size),
    .wr_data_in(wr_data_in), .rd_data_in(rd_data_in),
    .wr_data_out(wr_data_out), .rd_data_out(rd_data_out), .le_flag(le_flag)
  );

  function automatic logic [31:0] model(input bit le, input bit [1:0] sz, input logic [31:0] d);
    if (!le || sz == 2'b11) return d;
    if (sz == 2'b01) return {d[23:16], d[31:24], d[7:0], d[15:8]};
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; cfg_we = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic cfg_write(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // Drive one access in the low phase, sample 2 ns later.
  task automatic access(input string req, input logic [2:0] area, input logic [1:0] sz,
                        input bit exp_le);
    logic [31:0] w, r;
    w = 32'hA1B2C3D4 ^ {8'(area), 8'(sz), 16'h0};
    r = 32'h11223344 + {24'h0, 5'h0, area};
    @(negedge clk);
    acc_area = area; acc_size = sz; wr_data_in = w; rd_data_in = r;
    #2;
    chk({req, " flag"}, {31'h0, le_flag}, {31'h0, exp_le});
    chk({req, " wr"}, wr_data_out, model(exp_le, sz, w));
    chk({req, " rd"}, rd_data_out, model(exp_le, sz, r));
  endtask

  // R4, R1: after reset no area swaps
  task automatic t_reset_state();
    do_reset();
    for (int a = 0; a < 8; a++) access("R4 R1 reset", 3'(a), 2'b10, 1'b0);
  endtask

  // R7 then R8/R5: wrong offset ignored, high data bits dropped
  task automatic t_program_area3();
    do_reset();
    cfg_write(12'h7FC, 8'h03);
    access("R7 wrong offset", 3'd3, 2'b10, 1'b0);
    cfg_write(12'h7FE, 8'hF3);
    access("R8 R5 code 3", 3'd3, 2'b10, 1'b1);
    access("R9 word", 3'd3, 2'b10, 1'b1);
    access("R10 half", 3'd3, 2'b01, 1'b1);
    access("R11 byte", 3'd3, 2'b00, 1'b1);
    access("R12 rsvd size", 3'd3, 2'b11, 1'b1);
    access("R2 other area", 3'd2, 2'b10, 1'b0);
    access("R2 other area", 3'd4, 2'b10, 1'b0);
    access("R3 area0", 3'd0, 2'b10, 1'b0);
  endtask

  // R5: second write ignored
  task automatic t_write_once();
    cfg_write(12'h7FE, 8'h05);
    access("R5 locked old", 3'd3, 2'b10, 1'b1);
    access("R5 locked new", 3'd5, 2'b10, 1'b0);
  endtask

  // R2: every legal code selects its own area only; R3 area 0
  task automatic t_each_code();
    for (int c = 1; c <= 5; c++) begin
      do_reset();
      cfg_write(12'h7FE, 8'(c));
      for (int a = 0; a < 8; a++) access("R2 R3 code sweep", 3'(a), 2'b10, a == c);
    end
  endtask

  // R6: codes 6 and 7 act as none
  task automatic t_high_codes();
    for (int c = 6; c <= 7; c++) begin
      do_reset();
      cfg_write(12'h7FE, 8'(c));
      for (int a = 0; a < 8; a++) access("R6 high code", 3'(a), 2'b10, 1'b0);
    end
  endtask

  // R13: outputs follow inputs without a clock edge
  task automatic t_comb();
    do_reset();
    cfg_write(12'h7FE, 8'h01);
    @(negedge clk);
    acc_area = 3'd1; acc_size = 2'b10; rd_data_in = 32'h0A0B0C0D; wr_data_in = 32'h01020304;
    #1;
    chk("R13 same cycle rd", rd_data_out, 32'h0D0C0B0A);
    rd_data_in = 32'hCAFEF00D; acc_size = 2'b01;
    #1;
    chk("R13 same cycle change", rd_data_out, 32'hFECA0DF0);
    acc_area = 3'd2;
    #1;
    chk("R13 flag drops", {31'h0, le_flag}, 32'h0);
    chk("R13 passthru", wr_data_out, 32'h01020304);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_program_area3();
    t_write_once();
    t_each_code();
    t_high_codes();
    t_comb();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule